// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Each request is latched into a status register. The capture mode is fixed per source at build time: either a rising edge or a high level sets the bit. An enable register masks the latched requests, and the result is the pending set. The output is raised when any pending bit exists and the master enable allows it.

Software uses a word-addressed register bus with eight registers. The enable mask can be replaced whole, or bits can be set or cleared alone through separate set and clear registers, so no read-modify-write sequence is needed. Latched requests are cleared by writing ones to an acknowledge register. A vector register returns the number of the lowest-numbered pending source, or all ones when nothing is pending.

The bus has no valid/ready handshake and applies no back-pressure. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address and the current register state. There is no stream interface.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the status, pending, enable and master registers read zero, the vector reads 0xFFFFFFFF and the interrupt output is low.
- R2: The word offsets are fixed: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Offsets 3, 4 and 5 read zero. Writes to offsets 0, 1 and 6 change no state.
- R3: A write to offset 2 replaces the enable register with the written data. No other bus write changes the enable register, except the writes described in R4 and R5.
- R4: A write to offset 4 ORs the written data into the enable register and leaves bits that are zero in the data unchanged.
- R5: A write to offset 5 clears each enable bit where the written data has a one and leaves the other bits unchanged.
- R6: A write to offset 3 clears each status bit whose data bit is one. When a capture and an acknowledge hit the same bit in the same cycle, the capture wins.
- R7: For a source whose bit in the parameter EDGE_MASK is 1, a 0-to-1 input transition sets its status bit on the next clock edge. The bit then stays set, whether the input stays high or drops, until it is acknowledged. A held-high input does not set it again.
- R8: For a source whose bit in EDGE_MASK is 0, its status bit is set on every clock edge where the input is high. An acknowledge while the input is high therefore leaves the bit set.
- R9: Offset 1 reads the status bits ANDed with the enable bits.
- R10: Offset 6 reads the index of the lowest-numbered pending source, zero-extended, so source 0 has the highest priority. It reads 0xFFFFFFFF when no bit is pending.
- R11: The master register at offset 7 keeps data bits 1:0 and reads them back with all upper bits zero. The interrupt output is high exactly when master bit 0 is one and at least one bit is pending.
- R12: While master bit 0 is zero, the interrupt output stays low whatever is pending. Bit 1 alone does not enable the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N | Interrupt request lines, one per source |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the request lines and the bus signals are synchronous to clk and stable at each rising edge. They also assume that each bus write lasts one strobe cycle with a defined address. The bench meets these conditions by changing every input only on the falling edge. It writes each register in a single strobe cycle and holds the address steady during reads. One case drives a rising request and an acknowledge of the same bit in the same cycle, which is allowed and exercises the capture-wins rule.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;

  typedef enum logic [AW-1:0] {
    OFS_STAT   = 3'd0,
    OFS_PEND   = 3'd1,
    OFS_ENA    = 3'd2,
    OFS_ACK    = 3'd3,
    OFS_SETE   = 3'd4,
    OFS_CLRE   = 3'd5,
    OFS_VEC    = 3'd6,
    OFS_MASTER = 3'd7
  } ofs_e;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] status_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic hit;
    if (EDGE_MASK[i]) begin : g_edge
      logic last_q;
      always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= src_i[i];
      end
      assign hit = src_i[i] & ~last_q;
    end else begin : g_level
      assign hit = src_i[i];
    end

    // capture has priority over a same-cycle acknowledge
    always_ff @(posedge clk) begin
      if (!rst_n)     status_o[i] <= 1'b0;
      else if (hit)   status_o[i] <= 1'b1;
      else if (ack_i[i]) status_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/vic_enable.sv
module vic_enable #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en_o <= '0;
    else if (load_i) en_o <= data_i;
    else if (set_i)  en_o <= en_o | data_i;
    else if (clr_i)  en_o <= en_o & ~data_i;
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    // scan downward so the lowest set index is assigned last
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  ofs_e          ofs;
  logic [N-1:0]  wmask;
  logic [N-1:0]  ack_m;
  logic [N-1:0]  status_q;
  logic [N-1:0]  en_q;
  logic [N-1:0]  pend;
  logic [1:0]    master_q;
  logic          any_pend;
  logic [IW-1:0] top_idx;
  logic [DW-1:0] vec_rd;

  assign ofs   = ofs_e'(bus_addr);
  assign wmask = bus_wdata[N-1:0];
  assign ack_m = (bus_wr && ofs == OFS_ACK) ? wmask : '0;

  vic_capture #(.N(N), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .ack_i    (ack_m),
    .status_o (status_q)
  );

  vic_enable #(.N(N)) u_ena (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (bus_wr && ofs == OFS_ENA),
    .set_i  (bus_wr && ofs == OFS_SETE),
    .clr_i  (bus_wr && ofs == OFS_CLRE),
    .data_i (wmask),
    .en_o   (en_q)
  );

  assign pend = status_q & en_q;

  vic_prio #(.N(N)) u_prio (
    .pend_i (pend),
    .any_o  (any_pend),
    .idx_o  (top_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                         master_q <= 2'b00;
    else if (bus_wr && ofs == OFS_MASTER) master_q <= bus_wdata[1:0];
  end

  assign vec_rd = any_pend ? DW'(top_idx) : '1;
  assign irq_o  = master_q[0] & any_pend;

  always_comb begin
    unique case (ofs)
      OFS_STAT:   bus_rdata = DW'(status_q);
      OFS_PEND:   bus_rdata = DW'(pend);
      OFS_ENA:    bus_rdata = DW'(en_q);
      OFS_VEC:    bus_rdata = vec_rd;
      OFS_MASTER: bus_rdata = DW'(master_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  src_i,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          irq_o,
  input logic [N-1:0]  status_q,
  input logic [N-1:0]  en_q,
  input logic [1:0]    master_q,
  input logic [31:0]   vec_rd
);
  logic [N-1:0] ack_seen;
  logic         en_wr;
  assign ack_seen = (bus_wr && bus_addr == 3'd3) ? bus_wdata[N-1:0] : '0;
  assign en_wr    = bus_wr && (bus_addr == 3'd2 || bus_addr == 3'd4 || bus_addr == 3'd5);

  a_r3_enable_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));

  a_r4_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4) |=> en_q == ($past(en_q) | $past(bus_wdata[N-1:0])));

  a_r5_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd5) |=> en_q == ($past(en_q) & ~$past(bus_wdata[N-1:0])));

  a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & EDGE_MASK & ~ack_seen))
              == $past(status_q & EDGE_MASK & ~ack_seen)));

  a_r8_level_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(src_i & ~EDGE_MASK)) == $past(src_i & ~EDGE_MASK)));

  a_r10_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_q) == '0) |-> (vec_rd == 32'hFFFF_FFFF));

  a_r11_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_q & en_q) != '0));

  a_r12_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q[0] |-> !irq_o);
endmodule

bind vec_irq_ctrl vic_checker #(.N(N), .EDGE_MASK(EDGE_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .en_q      (en_q),
  .master_q  (master_q),
  .vec_rd    (vec_rd)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  localparam int unsigned N = 32;
  localparam logic [N-1:0] EMASK = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  vec_irq_ctrl #(.N(N), .EDGE_MASK(EMASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // monitor: compares mid-way through the low phase
  always begin
    @(negedge clk);
    #5;
    if (q_exp.size() > 0) begin
      int          k;
      logic [31:0] e;
      logic [31:0] a;
      string       t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = (k == 0) ? bus_rdata : {31'b0, irq_o};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr_src(input logic [2:0] a, input logic [31:0] d, input logic [N-1:0] s);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src = s;
  endtask

  task automatic drive_src(input logic [N-1:0] s);
    @(negedge clk);
    bus_wr = 1'b0; src = s;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic irq_is(input logic e, input string t);
    @(negedge clk);
    bus_wr = 1'b0;
    q_kind.push_back(1); q_exp.push_back({31'b0, e}); q_tag.push_back(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 32'h0, "R1 status");
    rd(3'd1, 32'h0, "R1 pending");
    rd(3'd2, 32'h0, "R1 enable");
    rd(3'd7, 32'h0, "R1 master");
    rd(3'd6, 32'hFFFF_FFFF, "R1 vector");
    irq_is(1'b0, "R1 irq");
    // enable paths
    wr(3'd2, 32'h0000_00F0);
    rd(3'd2, 32'h0000_00F0, "R3 direct enable");
    wr(3'd4, 32'h0F00_0001);
    rd(3'd2, 32'h0F00_00F1, "R4 set enable");
    wr(3'd5, 32'h0000_0030);
    rd(3'd2, 32'h0F00_00C1, "R5 clear enable");
    rd(3'd3, 32'h0, "R2 ack reads zero");
    rd(3'd4, 32'h0, "R2 set reads zero");
    rd(3'd5, 32'h0, "R2 clear reads zero");
    // level source 6
    drive_src(32'h0000_0040);
    rd(3'd0, 32'h0000_0040, "R8 level capture");
    rd(3'd1, 32'h0000_0040, "R9 pending");
    rd(3'd6, 32'h0000_0006, "R10 vector 6");
    irq_is(1'b0, "R12 master off");
    wr(3'd7, 32'h3);
    rd(3'd7, 32'h3, "R11 master readback");
    irq_is(1'b1, "R11 irq on");
    wr(3'd3, 32'h0000_0040);
    rd(3'd0, 32'h0000_0040, "R8 level survives ack");
    drive_src('0);
    wr(3'd3, 32'h0000_0040);
    rd(3'd0, 32'h0, "R6 ack clears");
    rd(3'd6, 32'hFFFF_FFFF, "R10 vector idle");
    irq_is(1'b0, "R11 irq off");
    // edge sources 20 and 24
    wr(3'd4, 32'h0110_0000);
    drive_src(32'h0010_0000);
    rd(3'd0, 32'h0010_0000, "R7 edge capture");
    drive_src('0);
    rd(3'd0, 32'h0010_0000, "R7 edge held after drop");
    drive_src(32'h0100_0000);
    rd(3'd0, 32'h0110_0000, "R7 second edge");
    rd(3'd6, 32'h0000_0014, "R10 vector 20");
    wr(3'd3, 32'h0010_0000);
    rd(3'd0, 32'h0100_0000, "R6 partial ack");
    rd(3'd6, 32'h0000_0018, "R10 vector 24");
    wr(3'd3, 32'h0100_0000);
    rd(3'd0, 32'h0, "R7 held input no recapture");
    drive_src('0);
    // writes to read-only offsets
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0, "R2 status not writable");
    rd(3'd2, 32'h0F10_00C1, "R2 enable untouched");
    // priority and master gating
    drive_src(32'h0000_0081);
    rd(3'd6, 32'h0, "R10 source 0 wins");
    wr(3'd5, 32'h0000_0001);
    rd(3'd6, 32'h0000_0007, "R10 vector 7");
    wr(3'd7, 32'h1);
    irq_is(1'b1, "R11 bit0 enables");
    wr(3'd7, 32'h2);
    rd(3'd7, 32'h2, "R11 master bit1");
    irq_is(1'b0, "R12 bit1 alone");
    wr(3'd7, 32'hFFFF_FFFC);
    rd(3'd7, 32'h0, "R11 upper bits dropped");
    irq_is(1'b0, "R12 master zero");
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0000_0081, "R8 ack all with level high");
    drive_src('0);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0, "R6 ack all");
    // capture versus acknowledge in one cycle
    wr_src(3'd3, 32'h0001_0000, 32'h0001_0000);
    rd(3'd0, 32'h0001_0000, "R6 capture wins");
    drive_src('0);
    wr(3'd3, 32'h0001_0000);
    rd(3'd0, 32'h0, "R6 edge cleared");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule